// File: doc/BRIEF.md
# Probe-Driven Best Next-Hop Table

This block is the state a switch keeps for load balancing driven by utilization probes. Top-of-rack switches send probes upward through the fabric. Each probe names a destination rack and carries the worst link utilization seen along the path so far. When a probe arrives on a local port, the block first raises the carried value to the utilization of the arrival link. It then decides whether that port becomes, or stays, the preferred next hop toward the named rack. Finally it emits the rewritten probe one cycle later, so that surrounding logic can replicate it to other ports.

For each destination the table holds exactly one next hop: the port whose path currently reports the lowest bottleneck utilization. A port that is already the stored best hop always refreshes its entry. This lets the stored value follow rising congestion instead of sticking at an old low reading.

Entries that go unrefreshed age out. A prescaler produces a tick every `TICK_DIV` cycles. An entry becomes invalid once it has seen `age_limit` ticks with no refresh. A limit of zero turns aging off.

The forwarding logic reads the table through a registered lookup port that runs every cycle.

Top module: `best_hop_table`

## Requirements
- R1: After reset every entry is invalid: lookups return lk_hit=0, lk_port=0 and lk_util=0, and fwd_valid is 0.
- R2: An accepted probe appears on the fwd_* outputs one cycle later. fwd_dest equals the probe's destination, and fwd_util equals the larger of probe_util and link_util.
- R3: A probe for a destination whose entry is invalid writes that entry with its arrival port and merged utilization, and marks it valid.
- R4: A probe from a different port replaces a valid entry only when its merged utilization is strictly lower than the stored value. An equal value leaves the entry unchanged.
- R5: A probe from a different port whose merged utilization is higher than the stored value changes neither the port nor the utilization of the entry.
- R6: A probe arriving on the stored best port always rewrites the entry with its merged utilization, even when that value is higher.
- R7: The lookup result for lk_dest appears one cycle after lk_dest is presented. A miss returns a zero port and zero utilization.
- R8: When a probe update and a lookup hit the same entry in the same cycle, the lookup returns the value from before the update. The new value is returned from the following cycle on.
- R9: With a nonzero age_limit, an entry that receives no refresh for age_limit prescaler ticks becomes invalid. The next probe for that destination then overwrites it, whatever its port or utilization.
- R10: With age_limit equal to 0, entries never expire.
- R11: A probe changes only the entry of its own destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| age_limit | input | 4 | Ticks without refresh before an entry expires; 0 disables aging |
| probe_valid | input | 1 | A probe is present this cycle |
| probe_dest | input | 6 | Destination rack of the probe |
| probe_util | input | 8 | Path-maximum utilization carried by the probe |
| probe_port | input | 4 | Local port the probe arrived on |
| link_util | input | 8 | Utilization of the arrival link |
| fwd_valid | output | 1 | Rewritten probe is valid |
| fwd_dest | output | 6 | Destination of the rewritten probe |
| fwd_util | output | 8 | Merged path utilization of the rewritten probe |
| lk_dest | input | 6 | Destination to look up |
| lk_hit | output | 1 | Looked-up entry is valid |
| lk_port | output | 4 | Best next-hop port of the looked-up entry |
| lk_util | output | 8 | Path utilization of the looked-up entry |

## Verification
The bench first probes the tie case: an equal utilization from another port must not move the hop, and a design that compared with less-or-equal would keep flipping ports. It then sends a higher reading from the stored best port, which a plain minimum filter would throw away, leaving the stale low value in place. A lookup placed in the same cycle as an update must return the old entry; a design that bypassed the write value would show the new one a cycle early. The bench also runs an aging case in which an expired entry must accept a worse path, since a design that never cleared validity would reject it, and it checks that a limit of zero keeps entries alive indefinitely.

// File: rtl/hop_pkg.sv
package hop_pkg;
    localparam int UTIL_W   = 8;
    localparam int PORT_W   = 4;
    localparam int DEST_W   = 6;
    localparam int AGE_W    = 4;
    localparam int NUM_DEST = 1 << DEST_W;

    typedef logic [UTIL_W-1:0] util_t;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [DEST_W-1:0] dest_t;
    typedef logic [AGE_W-1:0]  age_t;

    typedef struct packed {
        logic  valid;
        dest_t dest;
        util_t util;
    } probe_t;

    typedef struct packed {
        logic  valid;
        port_t port;
        util_t util;
        age_t  age;
    } entry_t;

    function automatic util_t util_max(input util_t a, input util_t b);
        return (a > b) ? a : b;
    endfunction

    // Accept a probe into an entry: empty slot, strictly better path,
    // or a refresh from the hop already chosen.
    function automatic logic take_probe(input entry_t e, input port_t p, input util_t m);
        return !e.valid || (m < e.util) || (p == e.port);
    endfunction
endpackage

// File: rtl/hop_merge.sv
module hop_merge
    import hop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  probe_t in_probe,
    input  util_t  link_util,
    output util_t  merged,
    output probe_t out_probe
);
    assign merged = util_max(in_probe.util, link_util);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_probe <= '0;
        end else begin
            out_probe.valid <= in_probe.valid;
            out_probe.dest  <= in_probe.dest;
            out_probe.util  <= merged;
        end
    end

    // R2
    fwd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_probe.valid == $past(in_probe.valid));
    // R2
    fwd_not_below_chk: assert property (@(posedge clk) disable iff (rst)
        out_probe.valid |-> (out_probe.util >= $past(in_probe.util)) &&
                            (out_probe.util >= $past(link_util)));
endmodule

// File: rtl/hop_table.sv
module hop_table
    import hop_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  age_t  age_limit,
    input  logic  wr_en,
    input  dest_t wr_dest,
    input  port_t wr_port,
    input  util_t wr_util,
    input  dest_t lk_dest,
    output logic  lk_hit,
    output port_t lk_port,
    output util_t lk_util
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    entry_t           tbl_q [NUM_DEST];
    logic             accept;

    assign tick   = (pre_q == PRE_LAST);
    assign accept = wr_en && take_probe(tbl_q[wr_dest], wr_port, wr_util);

    always_ff @(posedge clk) begin
        if (rst || tick) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_DEST; i++) begin
            if (rst) begin
                tbl_q[i] <= '0;
            end else if (accept && (wr_dest == dest_t'(i))) begin
                tbl_q[i].valid <= 1'b1;
                tbl_q[i].port  <= wr_port;
                tbl_q[i].util  <= wr_util;
                tbl_q[i].age   <= '0;
            end else if (tick && tbl_q[i].valid && (age_limit != '0)) begin
                tbl_q[i].age <= tbl_q[i].age + 1'b1;
                if (tbl_q[i].age + 1'b1 >= age_limit) tbl_q[i].valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit  <= 1'b0;
            lk_port <= '0;
            lk_util <= '0;
        end else begin
            lk_hit  <= tbl_q[lk_dest].valid;
            lk_port <= tbl_q[lk_dest].valid ? tbl_q[lk_dest].port : '0;
            lk_util <= tbl_q[lk_dest].valid ? tbl_q[lk_dest].util : '0;
        end
    end

    // R7
    lk_registered_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit == $past(tbl_q[lk_dest].valid));
    // R7
    lk_miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_port == '0) && (lk_util == '0));
    // R3
    wr_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tbl_q[wr_dest].valid) |=> tbl_q[$past(wr_dest)].valid);
    // R5
    worse_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tbl_q[wr_dest].valid && (wr_port != tbl_q[wr_dest].port) &&
         (wr_util >= tbl_q[wr_dest].util))
        |=> tbl_q[$past(wr_dest)].util == $past(tbl_q[wr_dest].util));
endmodule

// File: rtl/best_hop_table.sv
module best_hop_table
    import hop_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AGE_W-1:0]  age_limit,
    input  logic              probe_valid,
    input  logic [DEST_W-1:0] probe_dest,
    input  logic [UTIL_W-1:0] probe_util,
    input  logic [PORT_W-1:0] probe_port,
    input  logic [UTIL_W-1:0] link_util,
    output logic              fwd_valid,
    output logic [DEST_W-1:0] fwd_dest,
    output logic [UTIL_W-1:0] fwd_util,
    input  logic [DEST_W-1:0] lk_dest,
    output logic              lk_hit,
    output logic [PORT_W-1:0] lk_port,
    output logic [UTIL_W-1:0] lk_util
);
    probe_t in_probe, out_probe;
    util_t  merged;

    assign in_probe.valid = probe_valid;
    assign in_probe.dest  = probe_dest;
    assign in_probe.util  = probe_util;

    hop_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .in_probe  (in_probe),
        .link_util (link_util),
        .merged    (merged),
        .out_probe (out_probe)
    );

    hop_table #(.TICK_DIV(TICK_DIV)) u_table (
        .clk       (clk),
        .rst       (rst),
        .age_limit (age_limit),
        .wr_en     (probe_valid),
        .wr_dest   (probe_dest),
        .wr_port   (probe_port),
        .wr_util   (merged),
        .lk_dest   (lk_dest),
        .lk_hit    (lk_hit),
        .lk_port   (lk_port),
        .lk_util   (lk_util)
    );

    assign fwd_valid = out_probe.valid;
    assign fwd_dest  = out_probe.dest;
    assign fwd_util  = out_probe.util;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !fwd_valid && !lk_hit);
endmodule

// File: tb/best_hop_table_bench.sv
`timescale 1ns/1ps
module best_hop_table_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] age_limit = '0;
    logic       probe_valid = 1'b0;
    logic [5:0] probe_dest = '0;
    logic [7:0] probe_util = '0;
    logic [3:0] probe_port = '0;
    logic [7:0] link_util = '0;
    logic       fwd_valid;
    logic [5:0] fwd_dest;
    logic [7:0] fwd_util;
    logic [5:0] lk_dest = '0;
    logic       lk_hit;
    logic [3:0] lk_port;
    logic [7:0] lk_util;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    best_hop_table u_best_hop_table (
        .clk(clk), .rst(rst), .age_limit(age_limit),
        .probe_valid(probe_valid), .probe_dest(probe_dest), .probe_util(probe_util),
        .probe_port(probe_port), .link_util(link_util),
        .fwd_valid(fwd_valid), .fwd_dest(fwd_dest), .fwd_util(fwd_util),
        .lk_dest(lk_dest), .lk_hit(lk_hit), .lk_port(lk_port), .lk_util(lk_util)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the commit edge.
    task automatic send(input int dest, input int port, input int util, input int link);
        probe_valid = 1'b1; probe_dest = 6'(dest); probe_port = 4'(port);
        probe_util = 8'(util); link_util = 8'(link);
        @(negedge clk);
        probe_valid = 1'b0;
    endtask

    task automatic look(input int dest);
        lk_dest = 6'(dest);
        @(negedge clk);
    endtask

    task automatic expect_entry(input string req, input int dest, input int hit,
                                input int port, input int util);
        look(dest);
        check({req, " hit"}, int'(lk_hit), hit);
        check({req, " port"}, int'(lk_port), port);
        check({req, " util"}, int'(lk_util), util);
    endtask

    task automatic t_reset;
        check("R1 fwd_valid", int'(fwd_valid), 0);
        expect_entry("R1 dest0", 0, 0, 0, 0);
        expect_entry("R1 dest63", 63, 0, 0, 0);
    endtask

    task automatic t_merge;
        send(5, 1, 40, 70);
        check("R2 valid", int'(fwd_valid), 1);
        check("R2 dest", int'(fwd_dest), 5);
        check("R2 util link larger", int'(fwd_util), 70);
        send(6, 2, 90, 30);
        check("R2 util probe larger", int'(fwd_util), 90);
        check("R2 dest second", int'(fwd_dest), 6);
        @(negedge clk);
        check("R2 valid drops", int'(fwd_valid), 0);
    endtask

    task automatic t_rules;
        send(10, 3, 50, 20);
        expect_entry("R3 first write", 10, 1, 3, 50);
        send(10, 4, 40, 10);
        expect_entry("R4 lower replaces", 10, 1, 4, 40);
        send(10, 5, 40, 40);
        expect_entry("R4 equal kept", 10, 1, 4, 40);
        send(10, 6, 80, 0);
        expect_entry("R5 higher ignored", 10, 1, 4, 40);
        send(10, 4, 20, 120);
        expect_entry("R6 same port refresh", 10, 1, 4, 120);
    endtask

    task automatic t_indep;
        send(11, 7, 30, 0);
        expect_entry("R11 other dest", 10, 1, 4, 120);
        expect_entry("R11 new dest", 11, 1, 7, 30);
        expect_entry("R11 untouched dest", 12, 0, 0, 0);
    endtask

    task automatic t_collide;
        send(12, 2, 60, 0);
        lk_dest = 6'd12;
        probe_valid = 1'b1; probe_dest = 6'd12; probe_port = 4'd8;
        probe_util = 8'd10; link_util = 8'd0;
        @(negedge clk);
        probe_valid = 1'b0;
        check("R8 old port", int'(lk_port), 2);
        check("R8 old util", int'(lk_util), 60);
        @(negedge clk);
        check("R8 new port", int'(lk_port), 8);
        check("R8 new util", int'(lk_util), 10);
    endtask

    task automatic t_noage;
        age_limit = 4'd0;
        send(30, 1, 10, 0);
        repeat (100) @(negedge clk);
        expect_entry("R10 no expiry", 30, 1, 1, 10);
    endtask

    task automatic t_age;
        age_limit = 4'd2;
        send(20, 3, 10, 0);
        repeat (4) @(negedge clk);
        expect_entry("R9 still live", 20, 1, 3, 10);
        repeat (40) @(negedge clk);
        expect_entry("R9 expired", 20, 0, 0, 0);
        send(20, 9, 200, 0);
        expect_entry("R9 overwrite", 20, 1, 9, 200);
        age_limit = 4'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_merge;
        t_rules;
        t_indep;
        t_collide;
        t_noage;
        t_age;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule